// File: doc/BRIEF.md
# Infrared Transmit Modulator with Alternating Segment Slots

This block turns a stream of run-length segments, written by a host over a small register bus, into the drive signal for one or two infrared emitters. Each segment is one byte: a mark/space flag and a duration counted in sample ticks. Two segment slots are played in strict alternation. Each time a slot is taken into play, an interrupt asks the host to refill it, so the host stays one segment ahead while the other slot is being played.

During a mark the output is either held at a steady level or gated by a carrier. The carrier's period and high-time are set in fixed time units of `CLK_PER_UNIT` clock cycles each (500 ns in the intended system). A polarity bit inverts the emitter level, and a two-bit mask chooses which emitter pins follow the signal. If a slot falls due while it is still empty, transmission stops and the output returns to its inactive level. Splitting long durations into segments is the host's job.

Register map (3-bit address): 0 control (bit0 transmit enable, bit1 interrupt enable, bit2 carrier enable); 1 carrier period (bits 6:0 period in units, bit7 polarity); 2 carrier high-time (bits 6:0); 3 emitter mask (bit0 emitter 1, bit1 emitter 2); 4 slot 0; 5 slot 1; 6 status (bit0 interrupt flag, bit1 busy, bit2 slot 0 full, bit3 slot 1 full). Reads of address 7 return zero.

Top module: `ir_tx_modulator`

## Requirements
- R1: Slots are played strictly in alternation. The first segment after a start always comes from slot 0 (address 4), the next from slot 1 (address 5), and so on.
- R2: In a segment byte, bits 6:0 give the duration in sample ticks and bit 7 set means mark (bit 7 clear means space). A segment taken at tick k sets the output level from the edge of tick k through tick k+d-1. A duration of 0 behaves as 1.
- R3: Taking a slot into play sets status bit0, and `tx_irq` equals that flag ANDed with control bit1. Writing status with bit0 = 0 clears the flag. Writing bit0 = 1 has no effect.
- R4: If the slot that is due is empty at the end of a segment, busy (status bit1) drops and the output goes inactive. The block stays stopped, even after a refill, until it is started again.
- R5: A start occurs only on the cycle after control bits 0 and 1 both become set. Clearing either bit stops transmission and returns the slot pointer to slot 0. A tick in the start cycle is ignored.
- R6: With control bit2 set and a non-zero period P, a mark is gated by a carrier that is high for max(H,1) of every P units (H is capped at P). The carrier phase restarts at the beginning of each mark.
- R7: With control bit2 clear, or with a period of 0, a mark drives a steady active level.
- R8: Bit 7 of the period register inverts the level of every unmasked emitter, whether idle or active.
- R9: Mask bit0 enables `emit1` and mask bit1 enables `emit2`. A masked pin is held low.
- R10: After reset the registers read as follows: control 0x00, period 0x20, high-time 0x10, mask 0x03, slots 0x00, status 0x00. `emit1`, `emit2` and `tx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse per sample period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| emit1 | output | 1 | Emitter 1 drive |
| emit2 | output | 1 | Emitter 2 drive |
| tx_irq | output | 1 | Slot-refill interrupt |

## Verification
The bench builds the block with `CLK_PER_UNIT` = 2. A four-unit carrier then repeats every eight clocks, so a window of eight samples gives an exact count of high cycles for each high-time setting. The sample tick is driven by the bench rather than derived from the clock, which lets segment boundaries, underrun and refill races be placed on chosen cycles with a few ticks. Short durations keep each segment sequence within a handful of ticks.

// File: rtl/ir_tx_pkg.sv
// Shared constants and types for the infrared transmit modulator.
// Assumes an 8-bit register bus with a 3-bit address.
package ir_tx_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int DUR_W  = 7;
    localparam int NSLOT  = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CPER  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CHIGH = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_SLOT0 = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd6;

    localparam logic [DUR_W-1:0] RST_PERIOD = 7'd32;
    localparam logic [DUR_W-1:0] RST_HIGH   = 7'd16;

    // One run-length segment: flag set means mark.
    typedef struct packed {
        logic             mark;
        logic [DUR_W-1:0] dur;
    } seg_t;
endpackage

// File: rtl/ir_tx_regs.sv
// Register file: control, carrier settings, emitter mask, two segment
// slots with full flags, and the sticky refill-interrupt flag.
// Assumes consume is a single-cycle pulse naming a full slot.
module ir_tx_regs
    import ir_tx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  consume,
    input  logic                  consume_idx,
    input  logic                  busy,
    output logic [DATA_W-1:0]     rdata,
    output logic [DATA_W-1:0]     ctrl,
    output logic [DUR_W-1:0]      car_period,
    output logic                  car_pol,
    output logic [DUR_W-1:0]      car_high,
    output logic [1:0]            mask,
    output seg_t [NSLOT-1:0]      slot,
    output logic [NSLOT-1:0]      slot_full,
    output logic                  irq_flag
);
    // Control, carrier and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            car_period <= RST_PERIOD;
            car_pol    <= 1'b0;
            car_high   <= RST_HIGH;
            mask       <= 2'b11;
        end else if (we) begin
            if (addr == ADR_CTRL)  ctrl <= wdata;
            if (addr == ADR_CPER)  {car_pol, car_period} <= wdata;
            if (addr == ADR_CHIGH) car_high <= wdata[DUR_W-1:0];
            if (addr == ADR_MASK)  mask <= wdata[1:0];
        end
    end

    // One storage byte and full flag per slot; a write beats a same-cycle consume.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g]      <= '0;
                slot_full[g] <= 1'b0;
            end else if (we && addr == ADR_SLOT0 + ADDR_W'(g)) begin
                slot[g]      <= wdata;
                slot_full[g] <= 1'b1;
            end else if (consume && consume_idx == 1'(g)) begin
                slot_full[g] <= 1'b0;
            end
        end
    end

    // Sticky interrupt flag: set on consume, cleared by writing a zero to bit0.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       irq_flag <= 1'b0;
        else if (consume)                                 irq_flag <= 1'b1;
        else if (we && addr == ADR_STAT && !wdata[0])     irq_flag <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            ADR_CTRL:         rdata = ctrl;
            ADR_CPER:         rdata = {car_pol, car_period};
            ADR_CHIGH:        rdata = {1'b0, car_high};
            ADR_MASK:         rdata = {6'b0, mask};
            ADR_SLOT0:        rdata = slot[0];
            ADR_SLOT0 + 3'd1: rdata = slot[1];
            ADR_STAT:         rdata = {4'b0, slot_full, busy, irq_flag};
            default:          rdata = '0;
        endcase
    end
endmodule

// File: rtl/ir_tx_seq.sv
// Segment sequencer: on each sample tick it counts down the current
// segment and, when that segment ends, takes the next slot in alternation,
// or stops if that slot is empty.
// Assumes sample_tick is a single-cycle pulse.
module ir_tx_seq
    import ir_tx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic                  tick,
    input  seg_t [NSLOT-1:0]      slot,
    input  logic [NSLOT-1:0]      slot_full,
    output logic                  consume,
    output logic                  consume_idx,
    output logic                  busy,
    output logic                  mark
);
    logic             go_q;
    logic             start;
    logic             running;
    logic             level;
    logic             cur;
    logic [DUR_W-1:0] remain;
    logic             fetch;
    logic [DUR_W-1:0] load_dur;

    assign start    = go && !go_q;
    assign fetch    = go && !start && running && tick && (remain <= 7'd1);
    assign consume  = fetch && slot_full[cur];
    assign consume_idx = cur;
    assign load_dur = (slot[cur].dur == '0) ? 7'd1 : slot[cur].dur;
    assign busy     = running;
    assign mark     = running && level;

    // Previous value of the enable, used to detect a start.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= go;
    end

    // Segment state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            running <= 1'b0;
            level   <= 1'b0;
            cur     <= 1'b0;
            remain  <= '0;
        end else if (start) begin
            running <= 1'b1;
            level   <= 1'b0;
            cur     <= 1'b0;
            remain  <= '0;
        end else if (running && tick) begin
            if (remain > 7'd1) begin
                remain <= remain - 7'd1;
            end else if (slot_full[cur]) begin
                remain <= load_dur;
                level  <= slot[cur].mark;
                cur    <= ~cur;
            end else begin
                running <= 1'b0;
                level   <= 1'b0;
                remain  <= '0;
            end
        end
    end
endmodule

// File: rtl/ir_tx_carrier.sv
// Carrier generator: divides the clock into time units and produces a
// waveform that is high for max(high,1) of every `period` units. The
// phase restarts whenever no mark is active.
// Assumes CLK_PER_UNIT >= 1.
module ir_tx_carrier
    import ir_tx_pkg::*;
#(
    parameter int CLK_PER_UNIT = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark,
    input  logic             enable,
    input  logic [DUR_W-1:0] period,
    input  logic [DUR_W-1:0] high,
    output logic             gate
);
    localparam int PRE_W = (CLK_PER_UNIT > 1) ? $clog2(CLK_PER_UNIT) : 1;

    logic             unit_tick;
    logic [DUR_W-1:0] cnt;
    logic [DUR_W-1:0] high_eff;
    logic             modulated;

    if (CLK_PER_UNIT == 1) begin : g_nodiv
        assign unit_tick = 1'b1;
    end else begin : g_div
        logic [PRE_W-1:0] pre;
        // Unit prescaler, held at zero outside marks.
        always_ff @(posedge clk) begin
            if (!rst_n || !mark)                     pre <= '0;
            else if (pre == PRE_W'(CLK_PER_UNIT-1))  pre <= '0;
            else                                     pre <= pre + 1'b1;
        end
        assign unit_tick = (pre == PRE_W'(CLK_PER_UNIT-1));
    end

    // Unit counter within one carrier period.
    always_ff @(posedge clk) begin
        if (!rst_n || !mark)  cnt <= '0;
        else if (unit_tick)   cnt <= (cnt >= period - 7'd1) ? '0 : cnt + 7'd1;
    end

    assign high_eff  = (high == '0) ? 7'd1 : high;
    assign modulated = enable && (period != '0);
    assign gate      = modulated ? (cnt < high_eff) : 1'b1;
endmodule

// File: rtl/ir_tx_modulator.sv
// Top of the infrared transmit modulator: registers, sequencer, carrier
// and emitter output stage with polarity and per-pin masking.
// Assumes sample_tick is generated elsewhere from the sample period.
module ir_tx_modulator
    import ir_tx_pkg::*;
#(
    parameter int CLK_PER_UNIT = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              emit1,
    output logic              emit2,
    output logic              tx_irq
);
    logic [DATA_W-1:0] ctrl;
    logic [DUR_W-1:0]  car_period;
    logic [DUR_W-1:0]  car_high;
    logic              car_pol;
    logic [1:0]        mask;
    seg_t [NSLOT-1:0]  slot;
    logic [NSLOT-1:0]  slot_full;
    logic              irq_flag;
    logic              consume;
    logic              consume_idx;
    logic              busy;
    logic              mark;
    logic              gate;
    logic              go;
    logic              level;

    assign go = ctrl[0] && ctrl[1];

    ir_tx_regs u_regs (
        .clk, .rst_n,
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .consume, .consume_idx, .busy,
        .rdata(reg_rdata), .ctrl, .car_period, .car_pol, .car_high,
        .mask, .slot, .slot_full, .irq_flag
    );

    ir_tx_seq u_seq (
        .clk, .rst_n, .go, .tick(sample_tick),
        .slot, .slot_full,
        .consume, .consume_idx, .busy, .mark
    );

    ir_tx_carrier #(.CLK_PER_UNIT(CLK_PER_UNIT)) u_car (
        .clk, .rst_n, .mark, .enable(ctrl[2]),
        .period(car_period), .high(car_high), .gate
    );

    // Output stage: gate the mark, apply polarity, then mask each pin.
    assign level  = (mark && gate) ^ car_pol;
    assign emit1  = mask[0] && level;
    assign emit2  = mask[1] && level;
    assign tx_irq = irq_flag && ctrl[1];
endmodule

// File: rtl/ir_tx_checker.sv
// Property checker for the infrared transmit modulator, bound to the top.
module ir_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl,
    input logic       consume,
    input logic       consume_idx,
    input logic       irq_flag,
    input logic       busy,
    input logic       mark,
    input logic [1:0] mask,
    input logic       emit1,
    input logic       emit2
);
    logic go, go_q, exp_idx;
    assign go = ctrl[0] && ctrl[1];

    // Independent model of the slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q    <= 1'b0;
            exp_idx <= 1'b0;
        end else begin
            go_q <= go;
            if (!go || !go_q)  exp_idx <= 1'b0;
            else if (consume)  exp_idx <= ~exp_idx;
        end
    end

    assert_alternate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> consume_idx == exp_idx);
    assert_irq_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> irq_flag);
    assert_idle_no_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mark);
    assert_stop_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !busy);
    assert_mask1_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask[0] |-> !emit1);
    assert_mask2_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask[1] |-> !emit2);
endmodule

bind ir_tx_modulator ir_tx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .consume(consume),
    .consume_idx(consume_idx), .irq_flag(irq_flag), .busy(busy),
    .mark(mark), .mask(mask), .emit1(emit1), .emit2(emit2)
);

// File: tb/sim_ir_tx_modulator.sv
module sim_ir_tx_modulator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       emit1, emit2, tx_irq;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    ir_tx_modulator #(.CLK_PER_UNIT(2)) u0 (
        .clk, .rst_n, .sample_tick, .reg_we, .reg_addr, .reg_wdata,
        .reg_rdata, .emit1, .emit2, .tx_irq
    );

    // Segment pairs {slot0, slot1} for the table walk (steady marks).
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h8302, 16'h0185, 16'h8003, 16'h8484, 16'h0000, 16'h8781
    };

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic tick();
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic start(input logic [7:0] c);
        wr(3'd0, 8'h00);
        wr(3'd0, c);
        @(negedge clk);
    endtask

    task automatic count_high(output int n);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (emit1) n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset values
        rd(3'd0, v); check("R10 ctrl", v, 8'h00);
        rd(3'd1, v); check("R10 period", v, 8'h20);
        rd(3'd2, v); check("R10 high", v, 8'h10);
        rd(3'd3, v); check("R10 mask", v, 8'h03);
        rd(3'd6, v); check("R10 status", v, 8'h00);
        check("R10 outputs", {emit1, emit2, tx_irq}, 0);

        // R1 R2 R4: table walk of two-segment sequences ending in underrun
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] a, b;
            int da, db, ex;
            a = VEC[k][15:8]; b = VEC[k][7:0];
            da = (a[6:0] == 0) ? 1 : int'(a[6:0]);
            db = (b[6:0] == 0) ? 1 : int'(b[6:0]);
            wr(3'd0, 8'h00);
            wr(3'd4, a); wr(3'd5, b);
            start(8'h03);
            for (int t = 1; t <= da + db + 2; t++) begin
                tick();
                ex = (t <= da) ? int'(a[7]) : (t <= da + db) ? int'(b[7]) : 0;
                check($sformatf("R2 vec%0d tick%0d", k, t), emit1, ex);
            end
            rd(3'd6, v); check("R4 busy low after underrun", v[1], 0);
        end

        // R5: only transmit-enable set -> no start
        wr(3'd0, 8'h00); wr(3'd4, 8'h85);
        start(8'h01);
        tick(); tick();
        check("R5 no start without irq enable", emit1, 0);
        rd(3'd6, v); check("R5 busy", v[1], 0);

        // R3: interrupt on take, write 1 no effect, write 0 clears
        wr(3'd6, 8'h00);
        start(8'h03);
        tick();
        check("R3 tx_irq set", tx_irq, 1);
        rd(3'd6, v); check("R3 flag set", v[0], 1);
        wr(3'd6, 8'h01);
        check("R3 write one keeps flag", tx_irq, 1);
        wr(3'd6, 8'h00);
        check("R3 write zero clears", tx_irq, 0);

        // R1: refill slot 0 while slot 1 pending, sequence continues in order
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h82); wr(3'd5, 8'h01);
        start(8'h03);
        tick();
        wr(3'd4, 8'h81);
        tick(); check("R1 slot0 second tick", emit1, 1);
        tick(); check("R1 slot1 space", emit1, 0);
        tick(); check("R1 refilled slot0 mark", emit1, 1);
        tick(); check("R4 underrun low", emit1, 0);
        // R4: refill after stop does not resume
        wr(3'd4, 8'h85); wr(3'd5, 8'h85);
        tick(); tick();
        check("R4 stays stopped", emit1, 0);
        rd(3'd6, v); check("R4 busy stays low", v[1], 0);

        // R9: mask only emitter 2
        wr(3'd3, 8'h02);
        start(8'h03);
        tick();
        check("R9 emit1 masked", emit1, 0);
        check("R9 emit2 active", emit2, 1);

        // R8: polarity inversion, idle and active
        wr(3'd0, 8'h00); wr(3'd3, 8'h01); wr(3'd1, 8'hA0);
        check("R8 idle inverted", emit1, 1);
        wr(3'd4, 8'h82);
        start(8'h03);
        tick();
        check("R8 mark inverted", emit1, 0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h20);

        // R6 R7: carrier gating during a long mark
        wr(3'd1, 8'h04); wr(3'd2, 8'h01); wr(3'd4, 8'hFF);
        start(8'h07);
        tick();
        count_high(n); check("R6 high 1 of 4", n, 2);
        wr(3'd2, 8'h00); @(negedge clk);
        count_high(n); check("R6 high zero acts as one", n, 2);
        wr(3'd2, 8'h03); @(negedge clk);
        count_high(n); check("R6 high 3 of 4", n, 6);
        wr(3'd1, 8'h00); @(negedge clk);
        count_high(n); check("R7 zero period steady", n, 8);
        wr(3'd1, 8'h04); wr(3'd0, 8'h03); @(negedge clk);
        count_high(n); check("R7 carrier disabled steady", n, 8);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule